// File: doc/BRIEF.md
# Output Path Power-Up Mute and Soft-Ramp Sequencer

This block sequences a converter output path from a silent, clamped state into normal playback and back again. After reset it holds the path powered down, with the outputs tied to ground and every processing block disabled. Only the clock-management logic is left running. When the clock detector reports that both the system clock and the frame clock are good, the sequencer releases the clamp. It then raises a 16-bit output level code toward a programmed common-mode value, one step per frame tick, and enters normal operation once that value is reached.

In normal operation the incoming audio samples pass straight through to the output stream. In every other state each sample word is replaced by zero. If the clocks are lost at any point after leaving power-down, the sequencer steps the level back down to ground and only then returns to power-down. From there it can start a new ramp once the clocks come back.

The sample path is a valid/ready stream with no storage. The output valid always equals the input valid, and the input ready always equals the output ready, in every state. A stalled downstream therefore stalls the upstream in the same cycle. Muted words are transferred under the same handshake as real ones, so no sample is dropped or repeated. The reset input asserts asynchronously and is released through a two-stage synchronizer, so the block leaves reset on the second rising clock edge after the reset pin goes high.

Top module: `outpath_seq`

## Requirements
- R1: While reset is active, and immediately after it is released, the state indication is 0 (power-down), the level code is 0, the clamp is 1 and every bit of the power-down enable vector is 1.
- R2: The state codes are power-down=0, ramp-up=1, normal=2 and ramp-down=3. The block stays in power-down while clk_ok is low. It moves to ramp-up on the first clock edge where clk_ok is high. In every state except power-down, the clamp is 0 and all power-down enables are 0.
- R3: In ramp-up with clk_ok high, each clock edge with frame_tick high raises the level by STEP, limited to cm_target. Without frame_tick the level does not change in any state.
- R4: In ramp-up with clk_ok high, the block enters normal on the clock edge after the level has reached cm_target. Normal is reachable only from ramp-up.
- R5: m_data equals s_data in normal and is all zeros in every other state.
- R6: m_valid equals s_valid and s_ready equals m_ready in every state, so back-pressure passes through with no buffering.
- R7: clk_ok low in ramp-up or normal moves the block to ramp-down on the next edge. In ramp-down, each edge with frame_tick high lowers the level by STEP, with a floor at 0.
- R8: Ramp-down ignores clk_ok. Once the level is 0, the next edge enters power-down and the clamp reasserts.
- R9: Asserting rst_n low in any state forces power-down with level 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| clk_ok | input | 1 | Clock detector reports system and frame clocks valid |
| frame_tick | input | 1 | One-cycle pulse per frame, paces the ramp |
| cm_target | input | 16 | Common-mode level code that ends the ramp |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_data | input | 32 | Input sample word |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Output sample ready |
| m_data | output | 32 | Output sample word, zero unless in normal |
| clamp_en | output | 1 | Ground clamp for the outputs |
| pd_en | output | 4 | Power-down enables of the processing blocks |
| level | output | 16 | Output level / offset code |
| state_o | output | 2 | Sequencer state code |

## Verification
The hardest case to reach from the ports is a loss of clocks in the middle of a ramp. This includes the case where clk_ok drops on the very edge that would otherwise raise the level, and the case where clk_ok comes back while the level is still falling. The stimulus table walks one continuous timeline that ramps up, holds in normal, loses the clocks, and toggles clk_ok and frame_tick on chosen edges during ramp-down. It then restarts and drops clk_ok again on a ticking edge at level 0. Directed tests then cover an asynchronous reset in the middle of a ramp and a zero target.

// File: rtl/outpath_seq_pkg.sv
package outpath_seq_pkg;
  typedef enum logic [1:0] {
    ST_PWRDN   = 2'd0,
    ST_RAMP_UP = 2'd1,
    ST_RUN     = 2'd2,
    ST_RAMP_DN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import outpath_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_ok,
  input  logic       at_target,
  input  logic       at_zero,
  output seq_state_e state_q
);
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWRDN:   if (clk_ok) state_d = ST_RAMP_UP;
      ST_RAMP_UP: if (!clk_ok) state_d = ST_RAMP_DN;
                  else if (at_target) state_d = ST_RUN;
      ST_RUN:     if (!clk_ok) state_d = ST_RAMP_DN;
      ST_RAMP_DN: if (at_zero) state_d = ST_PWRDN;
      default:    state_d = ST_PWRDN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PWRDN;
    else        state_q <= state_d;
  end

  assert_hold_pwrdn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWRDN && !clk_ok) |=> state_q == ST_PWRDN);
  assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWRDN || state_q == ST_RAMP_DN) |=> state_q != ST_RUN);
  assert_clock_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN || state_q == ST_RAMP_UP) && !clk_ok) |=> state_q == ST_RAMP_DN);
  assert_dn_completes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RAMP_DN && !at_zero) |=> state_q == ST_RAMP_DN);
endmodule

// File: rtl/level_ramp.sv
module level_ramp
  import outpath_seq_pkg::*;
#(
  parameter int LW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state,
  input  logic          clk_ok,
  input  logic          tick,
  input  logic [LW-1:0] target,
  output logic [LW-1:0] level_q,
  output logic          at_target,
  output logic          at_zero
);
  localparam logic [LW:0]   STEP_W  = (LW+1)'(STEP);
  localparam logic [LW-1:0] STEP_LW = LW'(STEP);

  logic [LW:0]   up_sum;
  logic [LW-1:0] up_next;
  logic [LW-1:0] dn_next;

  always_comb begin
    up_sum  = {1'b0, level_q} + STEP_W;
    up_next = (up_sum >= {1'b0, target}) ? target : up_sum[LW-1:0];
    dn_next = (level_q > STEP_LW) ? (level_q - STEP_LW) : '0;
  end

  assign at_target = (level_q >= target);
  assign at_zero   = (level_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else begin
      if (state == ST_PWRDN)                          level_q <= '0;
      else if (state == ST_RAMP_UP && clk_ok && tick) level_q <= up_next;
      else if (state == ST_RAMP_DN && tick)           level_q <= dn_next;
    end
  end

  assert_tick_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level_q));
  assert_dn_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAMP_DN) |=> level_q <= $past(level_q));
  assert_pwrdn_ground_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PWRDN) |-> level_q == '0);
endmodule

// File: rtl/sample_gate.sv
module sample_gate #(
  parameter int DW = 32
) (
  input  logic          pass_en,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  assign m_valid = s_valid;
  assign s_ready = m_ready;
  assign m_data  = pass_en ? s_data : '0;
endmodule

// File: rtl/outpath_seq.sv
module outpath_seq
  import outpath_seq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LW   = 16,
  parameter int NPD  = 4,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_ok,
  input  logic          frame_tick,
  input  logic [LW-1:0] cm_target,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          clamp_en,
  output logic [NPD-1:0] pd_en,
  output logic [LW-1:0] level,
  output logic [1:0]    state_o
);
  logic [1:0] rst_pipe;
  logic       rst_q;
  seq_state_e state;
  logic       at_target;
  logic       at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_q), .clk_ok(clk_ok),
    .at_target(at_target), .at_zero(at_zero), .state_q(state)
  );

  level_ramp #(.LW(LW), .STEP(STEP)) u_ramp (
    .clk(clk), .rst_n(rst_q), .state(state), .clk_ok(clk_ok),
    .tick(frame_tick), .target(cm_target), .level_q(level),
    .at_target(at_target), .at_zero(at_zero)
  );

  sample_gate #(.DW(DW)) u_gate (
    .pass_en(state == ST_RUN), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  assign clamp_en = (state == ST_PWRDN);
  assign state_o  = state;

  for (genvar i = 0; i < NPD; i++) begin : g_pd
    assign pd_en[i] = (state == ST_PWRDN);
  end

  assert_clamp_ground_R2: assert property (@(posedge clk) disable iff (!rst_q)
    clamp_en |-> (level == '0 && pd_en == '1));
  assert_mute_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (state_o != 2'd2) |-> m_data == '0);
  assert_run_level_R4: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(state_o == 2'd2)) |-> (level >= $past(cm_target)));
endmodule

// File: tb/sim_outpath_seq.sv
module sim_outpath_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_ok = 1'b0;
  logic        frame_tick = 1'b0;
  logic [15:0] cm_target = 16'd3;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [31:0] m_data;
  logic        clamp_en;
  logic [3:0]  pd_en;
  logic [15:0] level;
  logic [1:0]  state_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  outpath_seq u0 (
    .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .frame_tick(frame_tick),
    .cm_target(cm_target), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .clamp_en(clamp_en), .pd_en(pd_en), .level(level), .state_o(state_o)
  );

  // entry: {clk_ok, frame_tick, expected state, expected level}, cm_target = 3
  localparam logic [19:0] VEC [18] = '{
    {1'b0, 1'b1, 2'd0, 16'd0},  // R2 tick ignored in power-down
    {1'b1, 1'b0, 2'd1, 16'd0},  // R2 leave power-down
    {1'b1, 1'b0, 2'd1, 16'd0},  // R3 no tick, no step
    {1'b1, 1'b1, 2'd1, 16'd1},  // R3
    {1'b1, 1'b1, 2'd1, 16'd2},  // R3
    {1'b1, 1'b1, 2'd1, 16'd3},  // R3 reaches target
    {1'b1, 1'b1, 2'd2, 16'd3},  // R4 enter normal, level held
    {1'b1, 1'b1, 2'd2, 16'd3},  // R4
    {1'b0, 1'b0, 2'd3, 16'd3},  // R7 clock loss
    {1'b1, 1'b1, 2'd3, 16'd2},  // R8 clk_ok back is ignored
    {1'b0, 1'b0, 2'd3, 16'd2},  // R7
    {1'b1, 1'b1, 2'd3, 16'd1},  // R7
    {1'b1, 1'b1, 2'd3, 16'd0},  // R7 floor
    {1'b1, 1'b0, 2'd0, 16'd0},  // R8 back to power-down
    {1'b1, 1'b0, 2'd1, 16'd0},  // R2 restart
    {1'b0, 1'b1, 2'd3, 16'd0},  // R7 drop on a ticking edge, no step
    {1'b0, 1'b0, 2'd0, 16'd0},  // R8
    {1'b0, 1'b0, 2'd0, 16'd0}   // R2 held
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_ctrl(input logic [1:0] st, input string req);
    logic       exp_clamp;
    logic [3:0] exp_pd;
    exp_clamp = (st == 2'd0);
    exp_pd    = (st == 2'd0) ? 4'hF : 4'h0;
    check(clamp_en == exp_clamp && pd_en == exp_pd, req,
          {clamp_en, pd_en}, {exp_clamp, exp_pd});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    // R1 reset state while held in reset
    repeat (3) @(negedge clk);
    check(state_o == 2'd0 && level == 16'd0, "R1", {state_o, level}, 18'd0);
    check_ctrl(2'd0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(state_o == 2'd0 && level == 16'd0, "R1", {state_o, level}, 18'd0);

    // table walk
    for (int i = 0; i < 18; i++) begin
      logic [1:0]  est;
      logic [15:0] elv;
      logic [31:0] edata;
      @(negedge clk);
      clk_ok     = VEC[i][19];
      frame_tick = VEC[i][18];
      s_data     = 32'hA5C3_0000 + 32'(i);
      s_valid    = i[0];
      m_ready    = ~i[1];
      est = VEC[i][17:16];
      elv = VEC[i][15:0];
      @(posedge clk);
      #2;
      check(state_o == est && level == elv, "R3/R4/R7/R8 state+level",
            {state_o, level}, {est, elv});
      check_ctrl(est, "R2 clamp/pd");
      edata = (est == 2'd2) ? s_data : 32'd0;
      check(m_data == edata, "R5 sample gate", m_data, edata);
      check(m_valid == s_valid && s_ready == m_ready, "R6 handshake",
            {m_valid, s_ready}, {s_valid, m_ready});
    end

    // R9 async reset in the middle of a ramp
    @(negedge clk);
    cm_target = 16'd10; clk_ok = 1'b1; frame_tick = 1'b1;
    repeat (4) @(negedge clk);
    check(state_o == 2'd1 && level == 16'd3, "R3 ramp before reset",
          {state_o, level}, {2'd1, 16'd3});
    #2 rst_n = 1'b0;
    #1;
    check(state_o == 2'd0 && level == 16'd0, "R9 async reset",
          {state_o, level}, 18'd0);
    check_ctrl(2'd0, "R9 clamp");
    frame_tick = 1'b0; clk_ok = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 zero target: ramp-up for one edge, then normal with level 0
    cm_target = 16'd0; clk_ok = 1'b1;
    @(negedge clk);
    check(state_o == 2'd1, "R4 zero target ramp", state_o, 2'd1);
    @(negedge clk);
    check(state_o == 2'd2 && level == 16'd0, "R4 zero target normal",
          {state_o, level}, {2'd2, 16'd0});
    s_data = 32'h1234_5678; m_ready = 1'b0; s_valid = 1'b1;
    #1;
    check(m_data == 32'h1234_5678, "R5 pass in normal", m_data, 32'h1234_5678);
    check(s_ready == 1'b0 && m_valid == 1'b1, "R6 back-pressure",
          {s_ready, m_valid}, 2'b01);
    // R8 zero level: ramp-down lasts one edge
    clk_ok = 1'b0;
    @(negedge clk);
    check(state_o == 2'd3 && m_data == 32'd0, "R8 ramp-down muted",
          {state_o, m_data}, {2'd3, 32'd0});
    @(negedge clk);
    check(state_o == 2'd0 && clamp_en, "R8 clamp returns",
          {state_o, clamp_en}, {2'd0, 1'b1});

    done = 1'b1;
    finish_run();
  end
endmodule